// File: doc/BRIEF.md
# Reset and Interrupt Priority Resolver

This block looks at every reset and interrupt request that is active in a cycle and names the single source the processor should service next. There are two groups. Six non-maskable sources always come first, in a fixed ranking. Behind them sit fifteen maskable sources. Their default ranking is fixed, but a 4-bit promotion register can lift any one of them above all the other maskable sources.

A global mask input removes the whole maskable group from consideration. Requests are treated as levels. A source that holds its request is granted again on every cycle until the requester clears it. Any lower request that was passed over stays pending and competes again on the next cycle.

The grant is registered. It is a 5-bit source number with a valid flag. Sources 0 to 5 are the non-maskable group in rank order, and 6 to 20 are the maskable group in default order. The promotion register is written through a simple write strobe and is reloaded with its reset value by the synchronous reset.

Top module: `prio_resolver`

## Requirements
- R1: While `rst` is sampled high, the next clock edge gives `grant_vld` = 0 and `grant_idx` = 0, and the promotion register loads 4'b0110.
- R2: Non-maskable sources are `nmi_req[0]` (power-on or external reset), `[1]` (clock monitor reset), `[2]` (watchdog reset), `[3]` (non-maskable external interrupt), `[4]` (illegal opcode trap) and `[5]` (software trap). The lowest active bit wins and is reported as its own bit number (0 to 5).
- R3: Any active non-maskable request wins over every maskable request, whatever the mask and promotion settings.
- R4: With no promotion in effect, maskable bit k of `msk_req` is reported as source 6+k, and the lowest active bit wins. The bit order is: 0 external IRQ, 1 real-time tick, 2-4 input captures 1-3, 5-8 output compares 1-4, 9 capture 4/compare 5, 10 timer overflow, 11 pulse accumulator overflow, 12 pulse accumulator edge, 13 SPI done, 14 serial port.
- R5: The promotion value selects a maskable bit. Values 6 to 15 select bit (value-6), and values 0 to 4 select bit (value+10). If the selected bit is active, it wins over all other maskable bits. If it is not active, the default order applies.
- R6: Promotion value 5 selects no source and leaves the default order unchanged.
- R7: While `imask` is 1, all maskable requests are ignored. With no non-maskable request, `grant_vld` is then 0.
- R8: The grant reflects the requests, mask and promotion value sampled at the previous rising edge, exactly one cycle later. A request that is held is granted again on every cycle.
- R9: `prom_we` = 1 loads `prom_wdata` at the rising edge. The new value governs resolution from the following edge on. A later reset restores 4'b0110.
- R10: When no request survives the mask, `grant_vld` = 0 and `grant_idx` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| nmi_req | input | 6 | Non-maskable request levels, bit 0 ranked highest |
| msk_req | input | 15 | Maskable request levels, bit 0 ranked highest by default |
| imask | input | 1 | Global mask for the maskable group |
| prom_we | input | 1 | Write strobe for the promotion register |
| prom_wdata | input | 4 | New promotion value |
| grant_vld | output | 1 | A source is granted |
| grant_idx | output | 5 | Number of the granted source (0-20) |

## Verification
Request, mask and grant form a single registered stage. The bench drives these inputs on a falling edge and compares the grant on the next falling edge, which places exactly one rising edge between stimulus and check. A promotion write costs one extra edge. The bench therefore writes on one falling edge, applies requests on the next, and checks one cycle after that, so the new value has been used for exactly one resolution. The held-request check samples on three successive cycles to confirm that the same source is granted every cycle.

// File: rtl/prio_pkg.sv
package prio_pkg;

    localparam int NMI_N    = 6;
    localparam int MSK_N    = 15;
    localparam int SEL_W    = 4;
    localparam int IDX_W    = 5;
    localparam int POS_W    = 4;
    localparam logic [SEL_W-1:0] SEL_RST  = 4'b0110;
    localparam logic [SEL_W-1:0] SEL_NONE = 4'd5;

    typedef struct packed {
        logic             hit;
        logic [POS_W-1:0] pos;
    } pick_t;

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
    } grant_t;

    // Decode a promotion value into the maskable bit it lifts.
    function automatic pick_t promo_map(input logic [SEL_W-1:0] sel);
        pick_t r;
        r.hit = 1'b1;
        r.pos = '0;
        if (sel == SEL_NONE) begin
            r.hit = 1'b0;
        end else if (sel > SEL_NONE) begin
            r.pos = POS_W'(sel - SEL_W'(6));
        end else begin
            r.pos = POS_W'(sel + SEL_W'(10));
        end
        return r;
    endfunction

endpackage

// File: rtl/prio_fixed_pick.sv
module prio_fixed_pick
    import prio_pkg::*;
#(
    parameter int N = 6
) (
    input  logic [N-1:0] req,
    output pick_t        pick
);

    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick.hit = 1'b1;
                pick.pos = POS_W'(i);
            end
        end
    end

endmodule

// File: rtl/prio_promo_pick.sv
module prio_promo_pick
    import prio_pkg::*;
#(
    parameter int N = 15
) (
    input  logic [N-1:0]     req,
    input  logic             imask,
    input  logic [SEL_W-1:0] sel,
    output pick_t            pick
);

    logic [N-1:0] live;
    pick_t        dflt;
    pick_t        lift;

    assign live = imask ? '0 : req;
    assign lift = promo_map(sel);

    prio_fixed_pick #(.N(N)) i_dflt (
        .req  (live),
        .pick (dflt)
    );

    always_comb begin
        pick = dflt;
        if (lift.hit && (int'(lift.pos) < N) && live[lift.pos]) begin
            pick.hit = 1'b1;
            pick.pos = lift.pos;
        end
    end

endmodule

// File: rtl/prio_promo_reg.sv
module prio_promo_reg
    import prio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] wdata,
    output logic [SEL_W-1:0] sel
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= SEL_RST;
        end else if (we) begin
            sel <= wdata;
        end
    end

endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
    import prio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NMI_N-1:0]     nmi_req,
    input  logic [MSK_N-1:0]     msk_req,
    input  logic                 imask,
    input  logic                 prom_we,
    input  logic [SEL_W-1:0]     prom_wdata,
    output logic                 grant_vld,
    output logic [IDX_W-1:0]     grant_idx
);

    logic [SEL_W-1:0] sel;
    pick_t            nmi_pick;
    pick_t            msk_pick;
    grant_t           nxt;
    grant_t           cur;

    prio_promo_reg i_sel (
        .clk   (clk),
        .rst   (rst),
        .we    (prom_we),
        .wdata (prom_wdata),
        .sel   (sel)
    );

    prio_fixed_pick #(.N(NMI_N)) i_nmi (
        .req  (nmi_req),
        .pick (nmi_pick)
    );

    prio_promo_pick #(.N(MSK_N)) i_msk (
        .req   (msk_req),
        .imask (imask),
        .sel   (sel),
        .pick  (msk_pick)
    );

    always_comb begin
        nxt = '0;
        if (nmi_pick.hit) begin
            nxt.vld = 1'b1;
            nxt.idx = IDX_W'(nmi_pick.pos);
        end else if (msk_pick.hit) begin
            nxt.vld = 1'b1;
            nxt.idx = IDX_W'(NMI_N) + IDX_W'(msk_pick.pos);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end

    assign grant_vld = cur.vld;
    assign grant_idx = cur.idx;

endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk
    import prio_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [NMI_N-1:0] nmi_req,
    input logic [MSK_N-1:0] msk_req,
    input logic             imask,
    input logic             grant_vld,
    input logic [IDX_W-1:0] grant_idx
);

    // R3: a non-maskable request in the previous cycle yields a non-maskable grant
    a_r3_nmi_first: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(|nmi_req)) |-> (grant_vld && grant_idx < IDX_W'(NMI_N)));

    // R2: the top non-maskable source always wins
    a_r2_top_nmi: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(nmi_req[0])) |-> (grant_vld && grant_idx == '0));

    // R7: a masked maskable group with no non-maskable request gives no grant
    a_r7_masked: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(imask) && $past(nmi_req == '0)) |-> !grant_vld);

    // R10: no request at all gives no grant
    a_r10_idle: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(nmi_req == '0) && $past(msk_req == '0)) |-> !grant_vld);

    // R10: the index is zero whenever nothing is granted
    a_r10_idle_idx: assert property (@(posedge clk) disable iff (rst)
        !grant_vld |-> (grant_idx == '0));

    // R4: a granted index stays within the defined sources
    a_r4_range: assert property (@(posedge clk) disable iff (rst)
        grant_vld |-> (int'(grant_idx) < NMI_N + MSK_N));

endmodule

bind prio_resolver prio_resolver_chk i_chk (.*);

// File: tb/test_prio_resolver.sv
module test_prio_resolver;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  nmi_req = '0;
    logic [14:0] msk_req = '0;
    logic        imask = 1'b0;
    logic        prom_we = 1'b0;
    logic [3:0]  prom_wdata = '0;
    logic        grant_vld;
    logic [4:0]  grant_idx;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    prio_resolver i_prio_resolver (
        .clk(clk), .rst(rst), .nmi_req(nmi_req), .msk_req(msk_req),
        .imask(imask), .prom_we(prom_we), .prom_wdata(prom_wdata),
        .grant_vld(grant_vld), .grant_idx(grant_idx)
    );

    // entry: nmi(6) msk(15) imask(1) sel(4) exp_vld(1) exp_idx(5) = 32 bits
    localparam int NV = 17;
    localparam logic [31:0] VEC [NV] = '{
        {6'h00, 15'h0000, 1'b0, 4'd6,  1'b0, 5'd0 },  // R10
        {6'h3F, 15'h7FFF, 1'b0, 4'd6,  1'b1, 5'd0 },  // R2
        {6'h3E, 15'h7FFF, 1'b0, 4'd6,  1'b1, 5'd1 },  // R2
        {6'h20, 15'h0000, 1'b0, 4'd6,  1'b1, 5'd5 },  // R2
        {6'h08, 15'h0001, 1'b1, 4'd6,  1'b1, 5'd3 },  // R3 R7
        {6'h10, 15'h7FFF, 1'b0, 4'd3,  1'b1, 5'd4 },  // R3
        {6'h00, 15'h7FFF, 1'b0, 4'd6,  1'b1, 5'd6 },  // R4
        {6'h00, 15'h7FFE, 1'b0, 4'd6,  1'b1, 5'd7 },  // R4
        {6'h00, 15'h4000, 1'b0, 4'd6,  1'b1, 5'd20},  // R4
        {6'h00, 15'h7FFF, 1'b0, 4'd4,  1'b1, 5'd20},  // R5
        {6'h00, 15'h7FFF, 1'b0, 4'd0,  1'b1, 5'd16},  // R5
        {6'h00, 15'h7FFF, 1'b0, 4'd15, 1'b1, 5'd15},  // R5
        {6'h00, 15'h0101, 1'b0, 4'd14, 1'b1, 5'd14},  // R5
        {6'h00, 15'h0006, 1'b0, 4'd4,  1'b1, 5'd7 },  // R5 promoted idle
        {6'h00, 15'h7FFF, 1'b0, 4'd5,  1'b1, 5'd6 },  // R6
        {6'h00, 15'h4002, 1'b0, 4'd5,  1'b1, 5'd7 },  // R6
        {6'h00, 15'h7FFF, 1'b1, 4'd6,  1'b0, 5'd0 }   // R7
    };

    task automatic check(input string tag, input logic ev, input logic [4:0] ei);
        n_run++;
        if (grant_vld !== ev || grant_idx !== ei) begin
            n_fail++;
            $display("FAIL %s: vld=%0b idx=%0d expected vld=%0b idx=%0d",
                     tag, grant_vld, grant_idx, ev, ei);
        end
    endtask

    task automatic write_sel(input logic [3:0] v);
        @(negedge clk);
        prom_we = 1'b1; prom_wdata = v;
        @(negedge clk);
        prom_we = 1'b0;
    endtask

    task automatic apply(input logic [5:0] n, input logic [14:0] m, input logic im);
        nmi_req = n; msk_req = m; imask = im;
        @(negedge clk);
    endtask

    // Model built from R2-R7 and R10
    function automatic logic [5:0] model(input logic [5:0] n, input logic [14:0] m,
                                         input logic im, input logic [3:0] s);
        int p;
        for (int i = 0; i < 6; i++) if (n[i]) return {1'b1, 5'(i)};
        if (im) return 6'd0;
        case (s)
            4'd0: p = 10; 4'd1: p = 11; 4'd2: p = 12; 4'd3: p = 13; 4'd4: p = 14;
            4'd5: p = -1;
            default: p = int'(s) - 6;
        endcase
        if (p >= 0 && m[p]) return {1'b1, 5'(p + 6)};
        for (int i = 0; i < 15; i++) if (m[i]) return {1'b1, 5'(i + 6)};
        return 6'd0;
    endfunction

    initial begin
        #(10 * 20000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: expired expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [14:0] lf;
        logic [5:0]  e;
        repeat (2) @(negedge clk);
        check("R1 reset", 1'b0, 5'd0);
        rst = 1'b0;
        // R1: reset value 0110 lifts bit 0, which already ranks first
        apply(6'h00, 15'h0003, 1'b0);
        check("R1 sel after reset", 1'b1, 5'd6);

        // table walk
        for (int k = 0; k < NV; k++) begin
            write_sel(VEC[k][9:6]);
            apply(VEC[k][31:26], VEC[k][25:11], VEC[k][10]);
            check($sformatf("vec%0d R2-R7/R10", k), VEC[k][5], VEC[k][4:0]);
        end

        // R8: one-cycle latency and held level
        write_sel(4'd6);
        apply(6'h00, 15'h0000, 1'b0);
        nmi_req = '0; msk_req = 15'h0001;
        #1;
        check("R8 before edge", 1'b0, 5'd0);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check("R8 held request", 1'b1, 5'd6);
        end
        apply(6'h00, 15'h0000, 1'b0);
        check("R8 release", 1'b0, 5'd0);

        // R9: write timing and reset restore
        @(negedge clk);
        prom_we = 1'b1; prom_wdata = 4'd4; msk_req = 15'h4001;
        @(negedge clk);
        prom_we = 1'b0;
        check("R9 old value on write edge", 1'b1, 5'd6);
        @(negedge clk);
        check("R9 new value next edge", 1'b1, 5'd20);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 reset restores 0110", 1'b1, 5'd6);

        // sweep every promotion value and both mask states against model
        lf = 15'h1ACE;
        for (int s = 0; s < 16; s++) begin
            write_sel(4'(s));
            for (int im = 0; im < 2; im++) begin
                for (int r = 0; r < 4; r++) begin
                    lf = {lf[13:0], lf[14] ^ lf[13]};
                    e = model(6'h00, lf, 1'(im), 4'(s));
                    apply(6'h00, lf, 1'(im));
                    check($sformatf("sweep sel=%0d im=%0d R5 R6 R7", s, im), e[5], e[4:0]);
                end
                e = model(6'h00, 15'h7FFF, 1'(im), 4'(s));
                apply(6'h00, 15'h7FFF, 1'(im));
                check($sformatf("sweep all sel=%0d im=%0d R5 R6 R7", s, im), e[5], e[4:0]);
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule